// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block is the register-facing front end of a serial peripheral interface engine. It holds a transmit byte queue and a receive byte queue, each reachable from a simple register bus either as a full 32-bit word (four bytes at once) or as a single byte. The serial engine drains the transmit queue and fills the receive queue one byte at a time through a pair of byte streams. Shifting and bit-clock generation are outside this block.

Software watches progress through an event register. This register shows both live queue fill counts next to two threshold-driven flags: receive data ready and transmit room available. It also holds four sticky error flags for bytes that were refused. Each flag is cleared by writing a one to its position. A mask register with the same bit layout selects which flags drive the single interrupt line. A mode register holds the two thresholds.

Register word addresses are: 0 mode, 1 event, 2 mask, 3 transmit data, 4 receive data. A write or read takes effect on the clock edge where `bus_wr` or `bus_rd` is high. Read data appears on `bus_rdata` after that edge and holds until the next read.

Top module: `spi_evt_unit`

## Requirements
- R1: During reset and right after it, `irq` is 0, `tx_valid` is 0, both counts are 0, mask reads 0, and every flag is cleared (after which only the transmit-room flag may set by its condition).
- R2: A word write (`bus_byte`=0) to address 3 queues four bytes, sent on `tx_byte` in the order bits 31:24, 23:16, 15:8, 7:0. Each `tx_take` pulse removes the byte shown.
- R3: A byte write (`bus_byte`=1) to address 3 queues only bits 7:0.
- R4: A word read of address 4 removes four bytes and returns the first-received byte in bits 31:24. A byte read removes one byte and returns it in bits 7:0, with the upper bits zero.
- R5: The event register reports the receive count in bits 29:24 and the transmit count in bits 21:16. Each count tracks the queue contents and never exceeds DEPTH.
- R6: Bit 9 (receive ready) sets whenever the receive count is nonzero and at least the receive threshold. Bit 8 (transmit room) sets whenever the free transmit space is nonzero and at least the transmit threshold. Both stay set until cleared, and the condition wins over a clear in the same cycle.
- R7: Writing a 1 to event bits 9, 8 or 3:0 clears that flag. Writing 0 leaves it unchanged.
- R8: Refused operations leave the queues unchanged and set a sticky flag. These are: a bus write that does not fit (bit 0), a bus read with too few bytes, which returns 0 (bit 1), a serial push into a full receive queue (bit 2), and a take from an empty transmit queue (bit 3).
- R9: The mode register holds the transmit threshold in bits 13:8 and the receive threshold in bits 5:0. It resets to 4 and 3, so it reads 0x00000403.
- R10: `irq` equals the OR of (event flags AND mask) one cycle after the flags hold those values.
- R11: The mask register uses event bit positions 9, 8 and 3:0 and reads back what was written in those positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_byte | input | 1 | 1 selects a single-byte data access, 0 a word access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tx_byte | output | 8 | Oldest queued transmit byte |
| tx_valid | output | 1 | Transmit queue holds at least one byte |
| tx_take | input | 1 | Serial engine consumes `tx_byte` |
| rx_byte | input | 8 | Byte from the serial engine |
| rx_push | input | 1 | Store `rx_byte` into the receive queue |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench uses the default DEPTH of 32 bytes. At this depth eight word writes fill the transmit queue exactly, so the ninth write is a refusal. Thirty-three serial pushes overrun the receive queue. Either full count, 32, still fits inside the 6-bit count fields. The default thresholds of 4 and 3 let a three-byte receive tail raise the ready flag while a word read of it is refused. A later mode write to 20 and 1 shows the thresholds moving both flag conditions.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;

    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 32;
    localparam int LANES     = WORD_W / BYTE_W;
    localparam int FIELD_W   = 6;
    localparam int ADDR_W    = 3;

    localparam int RXCNT_LSB = 24;
    localparam int TXCNT_LSB = 16;
    localparam int BIT_RXNE  = 9;
    localparam int BIT_TXNF  = 8;
    localparam int BIT_TXUNF = 3;
    localparam int BIT_RXOVF = 2;
    localparam int BIT_RXUNF = 1;
    localparam int BIT_TXOVF = 0;
    localparam int TXTHR_LSB = 8;
    localparam int RXTHR_LSB = 0;

    localparam logic [FIELD_W-1:0] TXTHR_RST = 6'd4;
    localparam logic [FIELD_W-1:0] RXTHR_RST = 6'd3;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE   = 3'd0,
        REG_EVENT  = 3'd1,
        REG_MASK   = 3'd2,
        REG_TXDATA = 3'd3,
        REG_RXDATA = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic rxne;
        logic txnf;
        logic tx_unf;
        logic rx_ovf;
        logic rx_unf;
        logic tx_ovf;
    } evt_flags_t;

    typedef struct packed {
        logic [FIELD_W-1:0] tx_thr;
        logic [FIELD_W-1:0] rx_thr;
    } mode_t;

    function automatic evt_flags_t word_to_flags(input logic [WORD_W-1:0] w);
        evt_flags_t f;
        f.rxne   = w[BIT_RXNE];
        f.txnf   = w[BIT_TXNF];
        f.tx_unf = w[BIT_TXUNF];
        f.rx_ovf = w[BIT_RXOVF];
        f.rx_unf = w[BIT_RXUNF];
        f.tx_ovf = w[BIT_TXOVF];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] flags_to_word(input evt_flags_t f);
        logic [WORD_W-1:0] w;
        w            = '0;
        w[BIT_RXNE]  = f.rxne;
        w[BIT_TXNF]  = f.txnf;
        w[BIT_TXUNF] = f.tx_unf;
        w[BIT_RXOVF] = f.rx_ovf;
        w[BIT_RXUNF] = f.rx_unf;
        w[BIT_TXOVF] = f.tx_ovf;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_event(input logic [FIELD_W-1:0] rxc,
                                                     input logic [FIELD_W-1:0] txc,
                                                     input evt_flags_t f);
        logic [WORD_W-1:0] w;
        w = flags_to_word(f);
        w[RXCNT_LSB +: FIELD_W] = rxc;
        w[TXCNT_LSB +: FIELD_W] = txc;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_mode(input mode_t m);
        logic [WORD_W-1:0] w;
        w = '0;
        w[TXTHR_LSB +: FIELD_W] = m.tx_thr;
        w[RXTHR_LSB +: FIELD_W] = m.rx_thr;
        return w;
    endfunction

endpackage

// File: rtl/spi_evt_fifo.sv
// Byte queue with a multi-byte write side and a multi-byte read side.
// Lane 0 is always the oldest byte. DEPTH must be a power of two.
// The caller guarantees that push and pop counts are legal.
module spi_evt_fifo
    import spi_evt_pkg::*;
#(
    parameter int  DEPTH    = 32,
    parameter int  WR_LANES = 4,
    parameter int  RD_LANES = 1,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int PN_W     = $clog2(WR_LANES + 1),
    localparam int QN_W     = $clog2(RD_LANES + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [PN_W-1:0]            push_n,
    input  logic [WR_LANES*BYTE_W-1:0] push_data,
    input  logic [QN_W-1:0]            pop_n,
    output logic [RD_LANES*BYTE_W-1:0] peek,
    output logic [CNT_W-1:0]           count
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp;
    logic [PTR_W-1:0]  rp;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            wp    <= wp + PTR_W'(push_n);
            rp    <= rp + PTR_W'(pop_n);
            count <= count + CNT_W'(push_n) - CNT_W'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < WR_LANES; k++) begin
            if (!rst && k < int'(push_n))
                mem[wp + PTR_W'(k)] <= push_data[k*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        for (int k = 0; k < RD_LANES; k++)
            peek[k*BYTE_W +: BYTE_W] = mem[rp + PTR_W'(k)];
    end

endmodule

// File: rtl/spi_evt_csr.sv
// Register decode, acceptance of queue operations, event flags, mask, mode.
module spi_evt_csr
    import spi_evt_pkg::*;
#(
    parameter int  DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int LN_W  = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_byte,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic               tx_take,
    input  logic               rx_push,
    input  logic [CNT_W-1:0]   tx_cnt,
    input  logic [CNT_W-1:0]   rx_cnt,
    input  logic [WORD_W-1:0]  rx_peek,
    output logic [LN_W-1:0]    tx_push_n,
    output logic [WORD_W-1:0]  tx_push_data,
    output logic               tx_pop_n,
    output logic               rx_push_n,
    output logic [LN_W-1:0]    rx_pop_n,
    output evt_flags_t         flags,
    output evt_flags_t         mask
);

    mode_t             cfg;
    evt_flags_t        set_v;
    evt_flags_t        clr_v;
    logic [LN_W-1:0]   req_n;
    logic              tx_wr;
    logic              rx_rd;
    logic              tx_fit;
    logic              rx_enough;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] rx_value;
    int                tx_free;

    assign req_n     = bus_byte ? LN_W'(1) : LN_W'(LANES);
    assign tx_wr     = bus_wr && (bus_addr == REG_TXDATA);
    assign rx_rd     = bus_rd && (bus_addr == REG_RXDATA);
    assign tx_fit    = (int'(tx_cnt) + int'(req_n)) <= DEPTH;
    assign rx_enough = int'(rx_cnt) >= int'(req_n);
    assign tx_free   = DEPTH - int'(tx_cnt);

    assign tx_push_n = (tx_wr && tx_fit) ? req_n : '0;
    assign rx_pop_n  = (rx_rd && rx_enough) ? req_n : '0;
    assign tx_pop_n  = tx_take && (tx_cnt != '0);
    assign rx_push_n = rx_push && (int'(rx_cnt) < DEPTH);

    // Lane 0 is sent first: the most significant byte of a word write.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign tx_push_data[BYTE_W-1:0] =
                bus_byte ? bus_wdata[BYTE_W-1:0] : bus_wdata[WORD_W-1 -: BYTE_W];
        end else begin : g_rest
            assign tx_push_data[g*BYTE_W +: BYTE_W] =
                bus_byte ? '0 : bus_wdata[WORD_W-1-g*BYTE_W -: BYTE_W];
        end
        assign rx_word[WORD_W-1-g*BYTE_W -: BYTE_W] = rx_peek[g*BYTE_W +: BYTE_W];
    end

    assign rx_value = bus_byte ? {{(WORD_W-BYTE_W){1'b0}}, rx_peek[BYTE_W-1:0]} : rx_word;

    always_comb begin
        set_v        = '0;
        set_v.rxne   = (rx_cnt != '0) && (int'(rx_cnt) >= int'(cfg.rx_thr));
        set_v.txnf   = (tx_free != 0) && (tx_free >= int'(cfg.tx_thr));
        set_v.tx_ovf = tx_wr && !tx_fit;
        set_v.rx_unf = rx_rd && !rx_enough;
        set_v.rx_ovf = rx_push && (int'(rx_cnt) >= DEPTH);
        set_v.tx_unf = tx_take && (tx_cnt == '0);
        clr_v        = (bus_wr && bus_addr == REG_EVENT) ? word_to_flags(bus_wdata) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags      <= '0;
            mask       <= '0;
            cfg.tx_thr <= TXTHR_RST;
            cfg.rx_thr <= RXTHR_RST;
            bus_rdata  <= '0;
        end else begin
            flags <= evt_flags_t'((flags & ~clr_v) | set_v);
            if (bus_wr && bus_addr == REG_MODE) begin
                cfg.tx_thr <= bus_wdata[TXTHR_LSB +: FIELD_W];
                cfg.rx_thr <= bus_wdata[RXTHR_LSB +: FIELD_W];
            end
            if (bus_wr && bus_addr == REG_MASK)
                mask <= word_to_flags(bus_wdata);
            if (bus_rd) begin
                case (bus_addr)
                    REG_MODE:   bus_rdata <= pack_mode(cfg);
                    REG_EVENT:  bus_rdata <= pack_event(FIELD_W'(rx_cnt), FIELD_W'(tx_cnt), flags);
                    REG_MASK:   bus_rdata <= flags_to_word(mask);
                    REG_RXDATA: bus_rdata <= rx_enough ? rx_value : '0;
                    default:    bus_rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_evt_irq.sv
module spi_evt_irq
    import spi_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  evt_flags_t flags,
    input  evt_flags_t mask,
    output logic       irq
);

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= |(flags & mask);
    end

endmodule

// File: rtl/spi_evt_unit.sv
module spi_evt_unit
    import spi_evt_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_byte,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    input  logic              tx_take,
    input  logic [7:0]        rx_byte,
    input  logic              rx_push,
    output logic              irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int LN_W  = $clog2(LANES + 1);

    logic [CNT_W-1:0]  tx_cnt;
    logic [CNT_W-1:0]  rx_cnt;
    logic [LN_W-1:0]   tx_push_n;
    logic [WORD_W-1:0] tx_push_data;
    logic              tx_pop_n;
    logic              rx_push_n;
    logic [LN_W-1:0]   rx_pop_n;
    logic [WORD_W-1:0] rx_peek;
    evt_flags_t        flags;
    evt_flags_t        mask;

    spi_evt_csr #(.DEPTH(DEPTH)) csr_i (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_byte     (bus_byte),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .tx_take      (tx_take),
        .rx_push      (rx_push),
        .tx_cnt       (tx_cnt),
        .rx_cnt       (rx_cnt),
        .rx_peek      (rx_peek),
        .tx_push_n    (tx_push_n),
        .tx_push_data (tx_push_data),
        .tx_pop_n     (tx_pop_n),
        .rx_push_n    (rx_push_n),
        .rx_pop_n     (rx_pop_n),
        .flags        (flags),
        .mask         (mask)
    );

    spi_evt_fifo #(.DEPTH(DEPTH), .WR_LANES(LANES), .RD_LANES(1)) txq_i (
        .clk       (clk),
        .rst       (rst),
        .push_n    (tx_push_n),
        .push_data (tx_push_data),
        .pop_n     (tx_pop_n),
        .peek      (tx_byte),
        .count     (tx_cnt)
    );

    spi_evt_fifo #(.DEPTH(DEPTH), .WR_LANES(1), .RD_LANES(LANES)) rxq_i (
        .clk       (clk),
        .rst       (rst),
        .push_n    (rx_push_n),
        .push_data (rx_byte),
        .pop_n     (rx_pop_n),
        .peek      (rx_peek),
        .count     (rx_cnt)
    );

    spi_evt_irq irq_i (
        .clk   (clk),
        .rst   (rst),
        .flags (flags),
        .mask  (mask),
        .irq   (irq)
    );

    assign tx_valid = (tx_cnt != '0);

endmodule

// File: rtl/spi_evt_chk.sv
module spi_evt_chk
    import spi_evt_pkg::*;
#(
    parameter int  DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_byte,
    input logic              wdata_txovf,
    input logic              tx_take,
    input logic              rx_push,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic [CNT_W-1:0]  rx_cnt,
    input evt_flags_t        flags,
    input evt_flags_t        mask
);

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (int'(tx_cnt) <= DEPTH) && (int'(rx_cnt) <= DEPTH));

    assert_irq_delay_R10: assert property (@(posedge clk) disable iff (rst)
        irq == (|($past(flags) & $past(mask))));

    assert_tx_refuse_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_TXDATA && (int'(tx_cnt) + (bus_byte ? 1 : 4)) > DEPTH)
        |=> (flags.tx_ovf && tx_cnt <= $past(tx_cnt)));

    assert_rx_overrun_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_push && int'(rx_cnt) == DEPTH) |=> flags.rx_ovf);

    assert_tx_starve_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_take && tx_cnt == '0) |=> flags.tx_unf);

    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (flags.tx_ovf && !(bus_wr && bus_addr == REG_EVENT && wdata_txovf)) |=> flags.tx_ovf);

endmodule

bind spi_evt_unit spi_evt_chk #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .irq         (irq),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_byte    (bus_byte),
    .wdata_txovf (bus_wdata[0]),
    .tx_take     (tx_take),
    .rx_push     (rx_push),
    .tx_cnt      (tx_cnt),
    .rx_cnt      (rx_cnt),
    .flags       (flags),
    .mask        (mask)
);

// File: tb/spi_evt_unit_tb_top.sv
module spi_evt_unit_tb_top;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_byte = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        tx_take = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_push = 1'b0;
    logic        irq;

    always #4 clk = ~clk;

    spi_evt_unit #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_byte(bus_byte), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_take(tx_take),
        .rx_byte(rx_byte), .rx_push(rx_push), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0]  tq[$];
    logic [7:0]  rq[$];
    logic [5:0]  txt = 6'd4;
    logic [5:0]  rxt = 6'd3;
    logic        m_rxne = 0;
    logic        m_txnf = 0;
    logic [3:0]  m_st = '0;
    logic [31:0] m_mask = '0;

    function automatic logic [31:0] exp_evt();
        return {2'b0, 6'(rq.size()), 2'b0, 6'(tq.size()), 6'b0, m_rxne, m_txnf, 4'b0, m_st};
    endfunction

    function automatic logic exp_irq();
        return |({m_rxne, m_txnf} & m_mask[9:8]) | |(m_st & m_mask[3:0]);
    endfunction

    function automatic void upd();
        int free;
        free = DEPTH - tq.size();
        if (rq.size() != 0 && rq.size() >= int'(rxt)) m_rxne = 1;
        if (free != 0 && free >= int'(txt)) m_txnf = 1;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus(input logic [2:0] a, input bit wr, input bit byt,
                       input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = !wr; bus_byte = byt; bus_wdata = wd;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        rd = bus_rdata;
        repeat (2) @(negedge clk);
    endtask

    task automatic op_txw(input logic [31:0] w, input bit byt);
        logic [31:0] d;
        int n;
        bus(3'd3, 1, byt, w, d);
        n = byt ? 1 : 4;
        if (tq.size() + n <= DEPTH) begin
            if (byt) tq.push_back(w[7:0]);
            else begin
                tq.push_back(w[31:24]); tq.push_back(w[23:16]);
                tq.push_back(w[15:8]);  tq.push_back(w[7:0]);
            end
        end else m_st[0] = 1;
        upd();
    endtask

    task automatic op_rx(input bit byt, input string req);
        logic [31:0] d, e;
        int n;
        bus(3'd4, 0, byt, '0, d);
        n = byt ? 1 : 4;
        if (rq.size() >= n) begin
            if (byt) e = {24'b0, rq.pop_front()};
            else begin
                e[31:24] = rq.pop_front(); e[23:16] = rq.pop_front();
                e[15:8]  = rq.pop_front(); e[7:0]   = rq.pop_front();
            end
        end else begin
            e = '0; m_st[1] = 1;
        end
        check(req, d, e);
        upd();
    endtask

    task automatic op_take(input string req);
        logic [7:0] got;
        logic v;
        @(negedge clk);
        got = tx_byte; v = tx_valid;
        tx_take = 1;
        @(negedge clk);
        tx_take = 0;
        repeat (2) @(negedge clk);
        check({req, " valid"}, {31'b0, v}, {31'b0, tq.size() != 0});
        if (tq.size() != 0) check(req, {24'b0, got}, {24'b0, tq.pop_front()});
        else m_st[3] = 1;
        upd();
    endtask

    task automatic op_push(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b; rx_push = 1;
        @(negedge clk);
        rx_push = 0;
        repeat (2) @(negedge clk);
        if (rq.size() < DEPTH) rq.push_back(b);
        else m_st[2] = 1;
        upd();
    endtask

    task automatic op_evt(input string req);
        logic [31:0] d;
        bus(3'd1, 0, 0, '0, d);
        check(req, d, exp_evt());
        check("R10 irq", {31'b0, irq}, {31'b0, exp_irq()});
    endtask

    task automatic op_clr(input logic [31:0] v);
        logic [31:0] d;
        bus(3'd1, 1, 0, v, d);
        if (v[9]) m_rxne = 0;
        if (v[8]) m_txnf = 0;
        m_st = m_st & ~v[3:0];
        upd();
    endtask

    task automatic op_mask(input logic [31:0] v);
        logic [31:0] d;
        bus(3'd2, 1, 0, v, d);
        m_mask = v & 32'h0000_030F;
        bus(3'd2, 0, 0, '0, d);
        check("R11 mask readback", d, m_mask);
    endtask

    task automatic op_mode(input logic [31:0] v);
        logic [31:0] d;
        bus(3'd0, 1, 0, v, d);
        txt = v[13:8]; rxt = v[5:0];
        upd();
        bus(3'd0, 0, 0, '0, d);
        check("R9 mode readback", d, {18'b0, txt, 2'b0, rxt});
    endtask

    initial begin
        logic [31:0] d;
        int seed;
        seed = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        check("R1 irq in reset", {31'b0, irq}, 32'd0);
        check("R1 tx_valid in reset", {31'b0, tx_valid}, 32'd0);
        rst = 0;
        upd();
        bus(3'd0, 0, 0, '0, d);
        check("R9 mode reset value", d, 32'h0000_0403);
        bus(3'd2, 0, 0, '0, d);
        check("R1 mask reset", d, 32'd0);
        op_evt("R1 event after reset");

        // R2 word order, R3 byte write
        op_txw(32'hA1B2C3D4, 0);
        op_evt("R5 tx count");
        for (int i = 0; i < 4; i++) op_take("R2 word byte order");
        op_txw(32'h1234_565A, 1);
        op_evt("R3 single byte count");
        op_take("R3 byte write data");

        // R8 take from empty, R7 W1C
        op_take("R8 empty take");
        op_evt("R8 tx underflow flag");
        op_clr(32'h0);
        op_evt("R7 zero write keeps flags");
        op_clr(32'h0000_0008);
        op_evt("R7 one clears flag");

        // Fill transmit queue and overrun it
        for (int i = 0; i < DEPTH / 4; i++) op_txw(32'h10203040 + i, 0);
        op_clr(32'h0000_0100);
        op_evt("R6 no room flag when full");
        op_txw(32'hDEADBEEF, 0);
        op_evt("R8 tx overflow refused");
        op_txw(32'h0000_0077, 1);
        op_evt("R8 byte into full refused");
        for (int i = 0; i < DEPTH; i++) op_take("R2 drain");
        op_evt("R6 room flag after drain");
        op_clr(32'h0000_030F);

        // Receive threshold, irq, tail
        op_push(8'h11); op_push(8'h22);
        op_evt("R6 below rx threshold");
        op_push(8'h33);
        op_evt("R6 rx threshold reached");
        op_mask(32'hFFFF_FFFF);
        op_mask(32'h0000_0200);
        op_evt("R10 irq from rx ready");
        op_rx(0, "R8 word read of short tail");
        op_evt("R8 rx underflow flag");
        op_clr(32'h0000_0200);
        op_evt("R6 condition wins over clear");
        for (int i = 0; i < 3; i++) op_rx(1, "R4 byte drain");
        op_clr(32'h0000_0202);
        op_evt("R10 irq low after clear");

        op_push(8'hC1); op_push(8'hC2); op_push(8'hC3); op_push(8'hC4);
        op_rx(0, "R4 word read order");

        // Thresholds moved
        op_mode(32'h0000_1401);
        op_clr(32'h0000_0300);
        op_push(8'h5E);
        op_evt("R6 rx threshold of one");
        for (int i = 0; i < 4; i++) op_txw(32'h0102_0304 * (i + 1), 0);
        op_clr(32'h0000_0100);
        op_evt("R6 tx threshold twenty blocks room flag");
        for (int i = 0; i < 16; i++) op_take("R2 drain after mode");
        op_rx(1, "R4 byte after mode");
        op_mode(32'h0000_0403);

        // Receive overrun
        for (int i = 0; i < DEPTH + 1; i++) op_push(8'(i * 7 + 3));
        op_evt("R8 rx overrun");
        for (int i = 0; i < DEPTH / 4; i++) op_rx(0, "R4 drain words");
        op_clr(32'h0000_030F);
        op_evt("R7 all cleared");

        // Random mix
        op_mask(32'h0000_030F);
        for (int i = 0; i < 400; i++) begin
            case ($urandom_range(0, 9))
                0, 1: op_txw($urandom, 0);
                2:    op_txw($urandom, 1);
                3:    op_take("R2 random take");
                4, 5: op_push(8'($urandom));
                6:    op_rx(0, "R4 random word read");
                7:    op_rx(1, "R4 random byte read");
                8:    op_evt("R5 random event read");
                default: op_clr($urandom & 32'h0000_030F);
            endcase
        end
        op_evt("R5 final event");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule